// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog

This block is a watchdog timer reached through a small 32-bit register bus with a valid strobe, a write flag, a 12-bit byte address and separate write and read data. A down-counter counts the ticks left until expiry. It moves only on clock edges where an external tick enable is high and the run bit is set. When the count runs out the first time, a pending flag is set and the count restarts from the load register. If the flag is still set when the count runs out again, the block gives a one-cycle reset pulse, provided the reset-enable bit is also set.

Software keeps the watchdog from firing by writing to the kick register. This clears the pending flag and restarts the count. A key register guards the configuration. After reset the block is unlocked. Writing any value other than the 32-bit key locks it. While it is locked, writes to the other registers have no effect. Reads are always allowed, so software can read the key register back to confirm that the lock took effect.

Top module: `lockwd_top`

## Requirements
- R1: After reset the key register reads 0 (unlocked), control reads 0, load reads 0xFFFFFFFF, and `irq_o` and `wdog_rst_o` are low.
- R2: A write to the key register (byte address 0xC00) with 0x1ACCE551 unlocks the block, so the key register reads 0. A write of any other value locks it, so it reads 1. Writes to the key register are accepted in either state.
- R3: While locked, writes to load (0x000), control (0x008) and kick (0x00C) are ignored, and reads of every register still return their contents.
- R4: An unlocked write to load stores the value, and that value can be read back. The count restarts at once from the new value. A value of N gives expiry after N ticks, and 0 is treated as 1.
- R5: The count advances only on edges where `tick_en` is high and control bit 0 (run) is set. Writing 0 to control stops it.
- R6: The first expiry sets the pending flag and reloads the count from load. `irq_o` equals the pending flag ANDed with control bit 0.
- R7: An expiry while the flag is pending drives `wdog_rst_o` high for exactly one cycle after that tick edge, but only if control bits 0 and 1 are both set. With bit 1 clear, no pulse is given.
- R8: An unlocked write of any data to kick clears the pending flag and restarts the count from load.
- R9: When a load or kick write falls on the same edge as an expiring tick, the bus reload wins and that expiry is dropped.
- R10: Control reads back its two bits with all upper bits zero, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | High for a write access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Count enable from an external divider |
| irq_o | output | 1 | First-stage expiry interrupt |
| wdog_rst_o | output | 1 | Second-stage reset pulse |

## Verification
The properties assume the following about the inputs:
- `bus_addr` is stable while `bus_valid` is high.
- A single access occupies one cycle.
- `tick_en` may be high on the same edge as a bus write.

The stimulus drives each access for exactly one clock and changes the inputs only on the falling edge. It raises `tick_en` only inside explicit tick steps, except in the one case that checks a reload and an expiry arriving together. The reset-pulse property relies on an expiry being possible only on an edge with `tick_en` high. No stimulus bypasses that.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_LOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_KICK = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 12'hC00;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
    localparam logic [DATA_W-1:0] LOAD_RESET = '1;

    typedef enum logic [2:0] {
        SEL_LOAD,
        SEL_CTRL,
        SEL_KICK,
        SEL_KEY,
        SEL_NONE
    } sel_e;

    // bit 0 = run, bit 1 = reset enable
    typedef struct packed {
        logic rst_en;
        logic run_en;
    } ctrl_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LOAD: return SEL_LOAD;
            OFS_CTRL: return SEL_CTRL;
            OFS_KICK: return SEL_KICK;
            OFS_KEY:  return SEL_KEY;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] at_least_one(input logic [DATA_W-1:0] v);
        return (v == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : v;
    endfunction

endpackage

// File: rtl/lockwd_regs.sv
module lockwd_regs
    import lockwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] load_q,
    output ctrl_t             ctrl_q,
    output logic              locked_q,
    output logic              reload_req,
    output logic              kick_req,
    output logic [DATA_W-1:0] reload_val
);

    sel_e sel;
    logic wr;
    logic wr_open;

    assign sel     = decode(bus_addr);
    assign wr      = bus_valid && bus_write;
    assign wr_open = wr && !locked_q;

    assign kick_req   = wr_open && (sel == SEL_KICK);
    assign reload_req = wr_open && (sel == SEL_KICK || sel == SEL_LOAD);
    assign reload_val = (sel == SEL_LOAD) ? at_least_one(bus_wdata) : at_least_one(load_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= LOAD_RESET;
            ctrl_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            if (wr && sel == SEL_KEY)
                locked_q <= (bus_wdata != UNLOCK_KEY);
            if (wr_open && sel == SEL_LOAD)
                load_q <= bus_wdata;
            if (wr_open && sel == SEL_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LOAD: bus_rdata = load_q;
            SEL_CTRL: bus_rdata[1:0] = ctrl_q;
            SEL_KEY:  bus_rdata[0] = locked_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lockwd_counter.sv
module lockwd_counter
    import lockwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              run_en,
    input  logic              rst_en,
    input  logic              reload_req,
    input  logic              kick_req,
    input  logic [DATA_W-1:0] reload_val,
    input  logic [DATA_W-1:0] load_val,
    output logic              pending_q,
    output logic              pulse_q
);

    logic [DATA_W-1:0] cnt_q;
    logic              step;
    logic              expire;

    assign step   = run_en && tick_en;
    assign expire = step && (cnt_q <= {{(DATA_W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= LOAD_RESET;
            pending_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (reload_req) begin
                cnt_q <= reload_val;
                if (kick_req)
                    pending_q <= 1'b0;
            end else if (expire) begin
                cnt_q <= at_least_one(load_val);
                if (pending_q)
                    pulse_q <= rst_en;
                else
                    pending_q <= 1'b1;
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
    import lockwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    logic [DATA_W-1:0] load_q;
    ctrl_t             ctrl_q;
    logic              locked;
    logic              reload_req;
    logic              kick_req;
    logic [DATA_W-1:0] reload_val;
    logic              pending;
    logic              ctrl_run;
    logic              ctrl_rst;

    assign ctrl_run = ctrl_q.run_en;
    assign ctrl_rst = ctrl_q.rst_en;

    lockwd_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .load_q     (load_q),
        .ctrl_q     (ctrl_q),
        .locked_q   (locked),
        .reload_req (reload_req),
        .kick_req   (kick_req),
        .reload_val (reload_val)
    );

    lockwd_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .run_en     (ctrl_run),
        .rst_en     (ctrl_rst),
        .reload_req (reload_req),
        .kick_req   (kick_req),
        .reload_val (reload_val),
        .load_val   (load_q),
        .pending_q  (pending),
        .pulse_q    (wdog_rst_o)
    );

    assign irq_o = pending && ctrl_run;

endmodule

// File: rtl/lockwd_chk.sv
module lockwd_chk
    import lockwd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick_en,
    input logic              irq_o,
    input logic              wdog_rst_o,
    input logic              locked,
    input logic              ctrl_run,
    input logic              ctrl_rst,
    input logic              pending,
    input logic [DATA_W-1:0] load_q
);

    logic wr;
    assign wr = bus_valid && bus_write;

    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_KEY && bus_wdata == UNLOCK_KEY) |=> !locked);

    p_other_locks_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_KEY && bus_wdata != UNLOCK_KEY) |=> locked);

    p_locked_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_LOAD && locked) |=> $stable(load_q));

    p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_CTRL && locked) |=> ($stable(ctrl_run) && $stable(ctrl_rst)));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctrl_run && pending));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_o |=> !wdog_rst_o);

    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_o |-> $past(pending && ctrl_run && ctrl_rst && tick_en));

    p_kick_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_KICK && !locked) |=> !pending);

endmodule

bind lockwd_top lockwd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tick_en    (tick_en),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o),
    .locked     (locked),
    .ctrl_run   (ctrl_run),
    .ctrl_rst   (ctrl_rst),
    .pending    (pending),
    .load_q     (load_q)
);

// File: tb/tb_lockwd_top.sv
module tb_lockwd_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_LOAD = 12'h000;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_KICK = 12'h00C;
    localparam logic [11:0] A_KEY  = 12'hC00;
    localparam logic [31:0] KEY    = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq_o;
    logic        wdog_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockwd_top dut (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_en    (tick_en),
        .irq_o      (irq_o),
        .wdog_rst_o (wdog_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_KEY, d);  check("R1 key", d, 0);
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_LOAD, d); check("R1 load", d, 32'hFFFFFFFF);
        check("R1 irq", irq_o, 0);
        check("R1 rst", wdog_rst_o, 0);
        rd(12'h004, d); check("R10 unmapped", d, 0);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        wr(A_KEY, 32'h1);
        rd(A_KEY, d);  check("R2 locked", d, 1);
        wr(A_LOAD, 32'd5);
        rd(A_LOAD, d); check("R3 load ignored", d, 32'hFFFFFFFF);
        wr(A_CTRL, 32'd3);
        rd(A_CTRL, d); check("R3 ctrl ignored", d, 0);
        wr(A_KEY, 32'h1ACCE550);
        rd(A_KEY, d);  check("R2 near key locks", d, 1);
        wr(A_KEY, KEY);
        rd(A_KEY, d);  check("R2 unlocked", d, 0);
    endtask

    task automatic t_first_expiry;
        logic [31:0] d;
        wr(A_LOAD, 32'd3);
        rd(A_LOAD, d); check("R4 load readback", d, 3);
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, d); check("R10 ctrl bits only", d, 1);
        tick(2); check("R4 before expiry", irq_o, 0);
        tick(1); check("R6 irq at expiry", irq_o, 1);
        tick(3); check("R7 no pulse without bit1", wdog_rst_o, 0);
        check("R6 still pending", irq_o, 1);
        wr(A_CTRL, 32'd0);
        check("R6 irq masked", irq_o, 0);
        tick(5);
        wr(A_CTRL, 32'd1);
        check("R5 stopped keeps pending", irq_o, 1);
        wr(A_KICK, 32'hDEAD);
        check("R8 kick clears", irq_o, 0);
    endtask

    task automatic t_pulse;
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'd3);
        repeat (10) @(negedge clk);
        check("R5 no tick no count", irq_o, 0);
        tick(3); check("R6 first stage", irq_o, 1);
        tick(2); check("R7 not yet", wdog_rst_o, 0);
        tick(1); check("R7 pulse", wdog_rst_o, 1);
        @(negedge clk);
        check("R7 single cycle", wdog_rst_o, 0);
        wr(A_KICK, 32'd0);
    endtask

    task automatic t_kick;
        wr(A_LOAD, 32'd2);
        tick(1);
        wr(A_KICK, 32'd7);
        tick(1); check("R8 restart", irq_o, 0);
        tick(1); check("R8 expiry after restart", irq_o, 1);
        wr(A_KICK, 32'd0);
        tick(1);
        wr(A_KICK, 32'd0, 1'b1);
        check("R9 expiry dropped", irq_o, 0);
        tick(1); check("R9 reload full", irq_o, 0);
        tick(1); check("R9 later expiry", irq_o, 1);
        wr(A_KICK, 32'd0);
    endtask

    task automatic t_zero;
        logic [31:0] d;
        wr(A_LOAD, 32'd0);
        rd(A_LOAD, d); check("R4 zero stored", d, 0);
        tick(1); check("R4 zero acts as one", irq_o, 1);
        wr(A_KEY, 32'h0);
        wr(A_KICK, 32'd1);
        check("R3 kick ignored", irq_o, 1);
        wr(A_KEY, KEY);
        wr(A_KICK, 32'd1);
        check("R8 kick after unlock", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock();
        t_first_expiry();
        t_pulse();
        t_kick();
        t_zero();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule